// File: doc/BRIEF.md
# Line Sensor Exposure Sequencer

This block times the exposure of a line-scan image sensor and the pixel readout that comes after it. Each line has two phases. First the sensor integrates light. Then the programmed number of pixels is clocked out, qualified by line-valid, data-valid and a strobe that alternates on every pixel beat. Four exposure modes decide when integration starts and stops:

- two free-running modes, where the block starts each integration by itself and stops it with a counter;
- a single-trigger mode, where one external line opens the exposure window and closes it;
- a dual-trigger mode, where one line starts the exposure and a second line stops it.

Both trigger lines come in asynchronously and pass through a two-flop synchronizer before any edge is detected. In every mode the end of integration leads straight into readout. In the free-running modes the end of readout leads straight into the next integration. In the triggered modes the block goes back to idle and waits for the next start edge. A status output gives the current phase.

Top module: `exposure_seq`

## Requirements
- R1: With `mode_sel` = 1 (free run, programmed), each integration lasts `integ_time` clock cycles, with a value of 0 treated as 1. Readout follows at once, and the next integration starts in the cycle right after the last readout beat.
- R2: With `mode_sel` = 0 (free run, minimum), each integration lasts exactly one cycle, whatever `integ_time` holds. Otherwise it behaves as R1.
- R3: With `mode_sel` = 2 (single trigger), a falling edge on `trig_a` starts integration and a rising edge on `trig_a` ends it. A level change on the pin is first seen in `phase` at the third rising clock edge after the change.
- R4: With `mode_sel` = 3 (dual trigger), a rising edge on `trig_b` starts integration and a rising edge on `trig_a` ends it, with the same three-edge latency. An integration therefore lasts as many cycles as lie between the start change and the stop change on the pins.
- R5: Integration is always followed by readout in the next cycle. In modes 2 and 3, readout is followed by idle.
- R6: A readout lasts ceil(N/2) cycles when `tap_single` = 0 (two taps, a pixel pair per cycle) and N cycles when `tap_single` = 1 (one tap, a pixel per cycle). N is `pix_count`, and a value of 0 is treated as 1.
- R7: `lval` and `dval` are 1 in exactly the readout cycles. `strobe` is 1 on readout beats 0, 2, 4 and so on, and 0 on odd beats and outside readout.
- R8: Trigger edges that occur during readout have no effect: the readout keeps its length, and the block stays idle afterwards.
- R9: In mode 3, a rising edge on `trig_a` while idle (a stop with no start) is ignored and the block stays idle.
- R10: `phase` encodes 0 = idle, 1 = integrating, 2 = readout. During and right after reset, `phase` is 0 and `lval`, `dval` and `strobe` are 0.
- R11: In mode 3, a further rising edge on `trig_b` during integration neither ends nor restarts the exposure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Exposure mode: 0 free run min, 1 free run programmed, 2 single trigger, 3 dual trigger |
| integ_time | input | IW | Integration length in cycles for mode 1 |
| pix_count | input | PW | Pixels per line |
| tap_single | input | 1 | 0: two taps, pixel pair per cycle; 1: single tap, one pixel per cycle |
| trig_a | input | 1 | Asynchronous trigger line (stop; start and stop in mode 2) |
| trig_b | input | 1 | Asynchronous trigger line (start in mode 3) |
| phase | output | 2 | Current phase: idle, integrating, readout |
| lval | output | 1 | Line valid during readout |
| dval | output | 1 | Data valid per readout beat |
| strobe | output | 1 | Alternating pixel qualifier |

## Verification
The hardest cases to reach are trigger edges that land while a readout is still running, and a second start edge inside an exposure. Both depend on where the three-cycle synchronizer delay falls against the phase boundaries. The bench drives the trigger pins from one forked branch while a second branch follows `phase` at every falling clock edge. This lets it fire edges at known offsets from the observed start of readout, and time exposures with a random cycle spacing between the start and stop changes. The exposure length is then predicted directly from that spacing.

// File: rtl/expseq_pkg.sv
package expseq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_INTEG = 2'd1,
    PH_READ  = 2'd2
  } phase_e;

  localparam logic [1:0] MODE_FREE_MIN  = 2'd0;
  localparam logic [1:0] MODE_FREE_PROG = 2'd1;
  localparam logic [1:0] MODE_SINGLE    = 2'd2;
  localparam logic [1:0] MODE_DUAL      = 2'd3;

  localparam int TRIG_A = 0;
  localparam int TRIG_B = 1;

  function automatic logic is_free(input logic [1:0] m);
    return (m == MODE_FREE_MIN) || (m == MODE_FREE_PROG);
  endfunction

endpackage

// File: rtl/expseq_edge_sync.sv
module expseq_edge_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);

  for (genvar g = 0; g < W; g++) begin : g_line
    logic meta, stable, prev;

    always_ff @(posedge clk) begin
      if (rst) begin
        meta   <= 1'b0;
        stable <= 1'b0;
        prev   <= 1'b0;
      end else begin
        meta   <= din[g];
        stable <= meta;
        prev   <= stable;
      end
    end

    assign rise[g] = stable & ~prev;
    assign fall[g] = ~stable & prev;
  end

endmodule

// File: rtl/expseq_integ_timer.sv
module expseq_integ_timer #(
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [IW-1:0] load_val,
  input  logic          run,
  output logic          expire
);

  localparam logic [IW-1:0] ONE = {{(IW-1){1'b0}}, 1'b1};

  logic [IW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= ONE;
    end else if (load) begin
      remain <= load_val;
    end else if (run && remain > ONE) begin
      remain <= remain - ONE;
    end
  end

  assign expire = run && (remain == ONE);

  // R1: a load of zero would make the exposure run far past its setting
  a_r1_load_nonzero: assert property (@(posedge clk) disable iff (rst)
    load |-> (load_val != '0));

  // R1: the counter moves down by exactly one per running cycle
  a_r1_count_step: assert property (@(posedge clk) disable iff (rst)
    (run && !load && remain > ONE) |=> (remain == $past(remain) - ONE));

endmodule

// File: rtl/expseq_readout.sv
module expseq_readout #(
  parameter int PW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          tap_single,
  input  logic [PW-1:0] pix_count,
  input  logic          active,
  output logic          last,
  output logic          lval,
  output logic          dval,
  output logic          strobe
);

  localparam logic [PW-1:0] ONE = {{(PW-1){1'b0}}, 1'b1};

  logic [PW-1:0] beat_idx;
  logic [PW-1:0] final_idx;
  logic [PW:0]   pair_cnt;
  logic [PW-1:0] final_calc;

  assign pair_cnt = ({1'b0, pix_count} + {{PW{1'b0}}, 1'b1}) >> 1;

  always_comb begin
    if (pix_count == '0) begin
      final_calc = '0;
    end else if (tap_single) begin
      final_calc = pix_count - ONE;
    end else begin
      final_calc = pair_cnt[PW-1:0] - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_idx  <= '0;
      final_idx <= '0;
    end else if (start) begin
      beat_idx  <= '0;
      final_idx <= final_calc;
    end else if (active && !last) begin
      beat_idx <= beat_idx + ONE;
    end
  end

  assign last   = active && (beat_idx == final_idx);
  assign lval   = active;
  assign dval   = active;
  assign strobe = active && !beat_idx[0];

  // R7: first beat of every readout carries a high strobe
  a_r7_first_strobe: assert property (@(posedge clk) disable iff (rst)
    start |=> (!active || strobe));

  // R7: strobe alternates from beat to beat
  a_r7_strobe_alt: assert property (@(posedge clk) disable iff (rst)
    (active && !last && !start) |=> (strobe != $past(strobe)));

  // R6: the beat index never passes the final beat
  a_r6_idx_bound: assert property (@(posedge clk) disable iff (rst)
    active |-> (beat_idx <= final_idx));

endmodule

// File: rtl/exposure_seq.sv
module exposure_seq
  import expseq_pkg::*;
#(
  parameter int IW = 16,
  parameter int PW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    mode_sel,
  input  logic [IW-1:0] integ_time,
  input  logic [PW-1:0] pix_count,
  input  logic          tap_single,
  input  logic          trig_a,
  input  logic          trig_b,
  output logic [1:0]    phase,
  output logic          lval,
  output logic          dval,
  output logic          strobe
);

  localparam int NTRIG = 2;
  localparam logic [IW-1:0] IONE = {{(IW-1){1'b0}}, 1'b1};

  phase_e        cur_ph, nxt_ph;
  logic [1:0]    mode_q;
  logic [NTRIG-1:0] t_rise, t_fall;
  logic          tmr_load, tmr_run, tmr_expire;
  logic          ro_start, ro_active, ro_last;
  logic [IW-1:0] integ_load;
  logic          stop_hit;

  expseq_edge_sync #(.W(NTRIG)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({trig_b, trig_a}),
    .rise (t_rise),
    .fall (t_fall)
  );

  assign integ_load = (mode_sel == MODE_FREE_MIN || integ_time == '0) ? IONE : integ_time;
  assign tmr_run    = (cur_ph == PH_INTEG) && is_free(mode_q);

  expseq_integ_timer #(.IW(IW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (integ_load),
    .run      (tmr_run),
    .expire   (tmr_expire)
  );

  assign ro_active = (cur_ph == PH_READ);

  expseq_readout #(.PW(PW)) u_read (
    .clk        (clk),
    .rst        (rst),
    .start      (ro_start),
    .tap_single (tap_single),
    .pix_count  (pix_count),
    .active     (ro_active),
    .last       (ro_last),
    .lval       (lval),
    .dval       (dval),
    .strobe     (strobe)
  );

  assign stop_hit = is_free(mode_q) ? tmr_expire : t_rise[TRIG_A];

  always_comb begin
    nxt_ph   = cur_ph;
    tmr_load = 1'b0;
    ro_start = 1'b0;
    case (cur_ph)
      PH_IDLE: begin
        if (is_free(mode_sel)) begin
          nxt_ph   = PH_INTEG;
          tmr_load = 1'b1;
        end else if (mode_sel == MODE_SINGLE && t_fall[TRIG_A]) begin
          nxt_ph = PH_INTEG;
        end else if (mode_sel == MODE_DUAL && t_rise[TRIG_B]) begin
          nxt_ph = PH_INTEG;
        end
      end
      PH_INTEG: begin
        if (stop_hit) begin
          nxt_ph   = PH_READ;
          ro_start = 1'b1;
        end
      end
      PH_READ: begin
        if (ro_last) begin
          if (is_free(mode_sel)) begin
            nxt_ph   = PH_INTEG;
            tmr_load = 1'b1;
          end else begin
            nxt_ph = PH_IDLE;
          end
        end
      end
      default: nxt_ph = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_ph <= PH_IDLE;
      mode_q <= MODE_FREE_MIN;
    end else begin
      cur_ph <= nxt_ph;
      if (nxt_ph == PH_INTEG && cur_ph != PH_INTEG) begin
        mode_q <= mode_sel;
      end
    end
  end

  assign phase = cur_ph;

  // R5: integration can only hold or hand over to readout
  a_r5_integ_to_read: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_INTEG) |=> (phase == PH_INTEG || phase == PH_READ));

  // R1: free-running readout rolls straight into the next exposure
  a_r1_free_no_gap: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_READ && ro_last && is_free(mode_sel)) |=> (phase == PH_INTEG));

  // R8: a readout is never cut short
  a_r8_read_hold: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_READ && !ro_last) |=> (phase == PH_READ));

  // R9: in dual-trigger mode only the start line leaves idle
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE && mode_sel == MODE_DUAL && !t_rise[TRIG_B]) |=> (phase == PH_IDLE));

  // R7: line valid is confined to readout
  a_r7_lval_read: assert property (@(posedge clk) disable iff (rst)
    lval |-> (phase == PH_READ));

  // R10: phase never takes the unused code
  a_r10_phase_legal: assert property (@(posedge clk) disable iff (rst)
    phase != 2'd3);

endmodule

// File: tb/tb_exposure_seq.sv
module tb_exposure_seq;

  localparam int IW = 16;
  localparam int PW = 14;
  localparam logic [1:0] P_IDLE = 2'd0, P_INTEG = 2'd1, P_READ = 2'd2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    mode_sel = 2'd2;
  logic [IW-1:0] integ_time = '0;
  logic [PW-1:0] pix_count = '0;
  logic          tap_single = 1'b0;
  logic          trig_a = 1'b0;
  logic          trig_b = 1'b0;
  logic [1:0]    phase;
  logic          lval, dval, strobe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  exposure_seq #(.IW(IW), .PW(PW)) dut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .integ_time(integ_time),
    .pix_count(pix_count), .tap_single(tap_single), .trig_a(trig_a),
    .trig_b(trig_b), .phase(phase), .lval(lval), .dval(dval), .strobe(strobe)
  );

  function automatic int exp_beats(input int n, input bit single);
    if (n == 0) return 1;
    return single ? n : (n + 1) / 2;
  endfunction

  function automatic int exp_integ(input int mode, input int t);
    if (mode == 0 || t == 0) return 1;
    return t;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_phase(input logic [1:0] p, input int lim, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (phase != p && n < lim);
  endtask

  // Called at a sample where phase == p; counts samples while p holds.
  task automatic run_len(input logic [1:0] p, input string req, output int len);
    int bad = 0;
    len = 0;
    while (phase == p) begin
      if (p == P_READ) begin
        if (!lval || !dval || strobe != (len % 2 == 0)) bad++;
      end else begin
        if (lval || dval || strobe) bad++;
      end
      len++;
      @(negedge clk);
    end
    chk(bad == 0, (p == P_READ) ? "R7" : req, bad, 0, "output pattern in phase");
  endtask

  task automatic free_run(input int mode, input int t, input int n, input bit single);
    int w, li, lr;
    string rq;
    rq = (mode == 0) ? "R2" : "R1";
    mode_sel = mode[1:0]; integ_time = t[IW-1:0]; pix_count = n[PW-1:0]; tap_single = single;
    do_reset();
    wait_phase(P_INTEG, 20, w);
    for (int rep = 0; rep < 2; rep++) begin
      run_len(P_INTEG, rq, li);
      chk(li == exp_integ(mode, t), rq, li, exp_integ(mode, t), "integration length");
      chk(phase == P_READ, "R5", phase, P_READ, "phase after integration");
      run_len(P_READ, "R6", lr);
      chk(lr == exp_beats(n, single), "R6", lr, exp_beats(n, single), "readout length");
      chk(phase == P_INTEG, rq, phase, P_INTEG, "no gap after readout");
    end
  endtask

  // Exposure in mode 2 or 3 with H cycles between start and stop pin changes.
  task automatic trig_exposure(input int mode, input int h, input int n, input bit single,
                               input bit extra_start);
    int w, li, lr;
    string rq;
    rq = (mode == 2) ? "R3" : "R4";
    pix_count = n[PW-1:0]; tap_single = single;
    fork
      begin
        if (mode == 2) trig_a = 1'b0; else trig_b = 1'b1;
        for (int i = 1; i <= h; i++) begin
          @(negedge clk);
          if (extra_start && i == 2) trig_b = 1'b0;
          if (extra_start && i == 4) trig_b = 1'b1;
        end
        trig_a = 1'b1;
        repeat (2) @(negedge clk);
        if (mode == 3) trig_b = 1'b0;
      end
      begin
        wait_phase(P_INTEG, 40, w);
        chk(w == 3, rq, w, 3, "start latency in samples");
        run_len(P_INTEG, rq, li);
        chk(li == h, extra_start ? "R11" : rq, li, h, "triggered integration length");
        chk(phase == P_READ, "R5", phase, P_READ, "phase after integration");
        run_len(P_READ, "R6", lr);
        chk(lr == exp_beats(n, single), "R6", lr, exp_beats(n, single), "readout length");
        chk(phase == P_IDLE, "R5", phase, P_IDLE, "idle after triggered readout");
      end
    join
    if (mode == 3) trig_a = 1'b0;
    repeat (5) @(negedge clk);
    chk(phase == P_IDLE, "R9", phase, P_IDLE, "idle while waiting for start");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1 (completion)");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed, w, lr, bad;
    seed = $urandom(32'd7321);

    // R10 reset state
    @(negedge clk);
    chk(phase == P_IDLE && !lval && !dval && !strobe, "R10", phase, P_IDLE, "reset outputs");
    do_reset();
    @(negedge clk);
    chk(phase == P_IDLE && !lval, "R10", phase, P_IDLE, "idle after reset release");

    // Directed free-run corners
    free_run(1, 0, 0, 1'b0);
    free_run(0, 25, 5, 1'b0);
    free_run(1, 1, 1, 1'b1);
    free_run(1, 9, 8, 1'b0);
    // Random free-run
    for (int k = 0; k < 10; k++) begin
      free_run($urandom_range(0, 1), $urandom_range(0, 30), $urandom_range(0, 40),
               1'($urandom_range(0, 1)));
    end

    // Single-trigger mode
    mode_sel = 2'd2; trig_a = 1'b1; trig_b = 1'b0;
    do_reset();
    repeat (6) @(negedge clk);
    chk(phase == P_IDLE, "R3", phase, P_IDLE, "idle before start edge");
    trig_exposure(2, 1, 3, 1'b1, 1'b0);
    for (int k = 0; k < 6; k++) begin
      trig_exposure(2, $urandom_range(1, 20), $urandom_range(0, 30), 1'($urandom_range(0, 1)), 1'b0);
    end

    // R8: edges inside readout are ignored
    pix_count = 14'd30; tap_single = 1'b1;
    trig_a = 1'b0;
    repeat (4) @(negedge clk);
    trig_a = 1'b1;
    wait_phase(P_READ, 40, w);
    trig_a = 1'b0;
    repeat (3) @(negedge clk);
    trig_a = 1'b1;
    wait_phase(P_IDLE, 60, w);
    lr = w + 3;
    chk(lr == 30, "R8", lr, 30, "readout length with edges inside");
    bad = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (phase != P_IDLE) bad++;
    end
    chk(bad == 0, "R8", bad, 0, "cycles out of idle after in-readout edges");

    // Dual-trigger mode
    mode_sel = 2'd3; trig_a = 1'b0; trig_b = 1'b0;
    do_reset();
    repeat (4) @(negedge clk);
    trig_a = 1'b1;
    repeat (6) @(negedge clk);
    chk(phase == P_IDLE, "R9", phase, P_IDLE, "stop edge without start");
    trig_a = 1'b0;
    repeat (4) @(negedge clk);
    trig_exposure(3, 9, 6, 1'b0, 1'b1);
    trig_exposure(3, 1, 0, 1'b0, 1'b0);
    for (int k = 0; k < 6; k++) begin
      trig_exposure(3, $urandom_range(1, 20), $urandom_range(0, 30), 1'($urandom_range(0, 1)), 1'b0);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule